// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O controller that sits on a simple word-addressed register bus. Software drives pins through an output data register and a direction register. It can also change individual output bits without a read-modify-write, through two write-one registers: one that sets bits and one that clears them. Pin inputs pass through a two-flop synchroniser. The synchronised values can be read back at any time, whatever direction each pin has.

Every pin has its own interrupt detector. Three per-pin configuration bits choose the trigger: a sensitivity bit (edge or level), a polarity bit, and a both-edges bit. Edge events latch into a raw status bit, which stays set until software writes a one to the acknowledge register. Level status tracks the active condition on every cycle. Masked status is the raw status with masked pins removed, and a single interrupt output goes high whenever any masked status bit is set. The two pull configuration registers only store bits; they drive nothing.

Writes take one cycle (`bus_wr` high with address and data). Reads are combinational from `bus_addr`. Address bits [1:0] are ignored.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is held low at a clock edge, every register clears to zero. After that edge, `pin_out`, `pin_oe` and `irq_out` are 0 and every register reads 0. Zero in the enable and mask registers means no pin is enabled and no pin is masked.
- R2: The register at 0x00 can be read and written, and its value drives `pin_out`. The register at 0x08 can be read and written, and its value drives `pin_oe`, where bit value 1 makes the pin an output.
- R3: A write to 0x10 sets to 1 every output-data bit whose write bit is 1. A write to 0x14 clears to 0 every output-data bit whose write bit is 1. Write bits of 0 leave output data unchanged. Both of these addresses read as 0.
- R4: Reading 0x04 returns the pin inputs after two flops. A change on `pin_in` before clock edge k is visible on reads after edge k+1, for output and input pins alike.
- R5: The registers at 0x18 and 0x1C can be read and written and have no effect on any output other than their own readback.
- R6: Consider an enabled pin in edge mode (bit of 0x34 = 0) with the both-edges bit of 0x38 = 0. With polarity bit 0 of 0x3C, a synchronised 0→1 transition sets the pin's bit in raw status (0x24); with polarity bit 1, a 1→0 transition sets it. The bit is set on the edge after edge k+1 for a pin change before edge k, and it then stays set.
- R7: An enabled edge-mode pin with both-edges bit 1 sets its raw status bit on either transition, whatever its polarity bit.
- R8: An enabled pin with sensitivity bit 1 (level) has a raw status bit equal to the synchronised input XOR the polarity bit, one cycle later. Polarity 0 means active-high and 1 means active-low. A write to 0x30 cannot clear it while the level stays active.
- R9: Writing 1s to 0x30 clears the latched edge status of those pins. If a new qualifying edge arrives in the same cycle, the edge wins and the bit stays set. 0x30 reads as 0.
- R10: A pin whose bit in the enable register (0x20) is 0 has a raw status bit of 0 from the next cycle on. Setting the enable bit again resumes detection, and earlier edges are not remembered.
- R11: Masked status (0x28) equals raw status AND NOT the mask register (0x2C). `irq_out` is 1 exactly when masked status is non-zero.
- R12: Writes to 0x04, 0x24 and 0x28 are ignored. Reads of 0x0C and of any address with no register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Output enable per pin (1 = drive) |
| irq_out | output | 1 | Combined interrupt, high when any masked status bit is set |

## Verification
A wrong stored configuration bit shows up on `bus_rdata` as soon as that register is addressed. A corrupted output or direction bit shows up on `pin_out` or `pin_oe` in the very next cycle. A fault in the synchroniser or the detector shows up as raw status or `irq_out` one cycle early, one cycle late, or missing for a given pin transition. For that reason, the bench steps through the register addresses and compares every output against a behavioural reference model on every clock. A status bit that latches wrongly, or a clear that fails to take, stays wrong until the next acknowledge, so the fault remains visible for many cycles.

// File: rtl/gpio_irq_pkg.sv
// Package: shared register address map and word-decode helper for the GPIO
// controller. Assumes byte addresses with 32-bit words (bits [1:0] ignored).
package gpio_irq_pkg;

    localparam int ADDR_W = 8;
    typedef logic [ADDR_W-1:0] reg_addr_t;

    localparam reg_addr_t A_DOUT   = 8'h00;
    localparam reg_addr_t A_DIN    = 8'h04;
    localparam reg_addr_t A_DIR    = 8'h08;
    localparam reg_addr_t A_SET    = 8'h10;
    localparam reg_addr_t A_CLR    = 8'h14;
    localparam reg_addr_t A_PEN    = 8'h18;
    localparam reg_addr_t A_PTYP   = 8'h1C;
    localparam reg_addr_t A_IEN    = 8'h20;
    localparam reg_addr_t A_RAW    = 8'h24;
    localparam reg_addr_t A_MSTAT  = 8'h28;
    localparam reg_addr_t A_MASK   = 8'h2C;
    localparam reg_addr_t A_ACK    = 8'h30;
    localparam reg_addr_t A_SENSE  = 8'h34;
    localparam reg_addr_t A_BOTH   = 8'h38;
    localparam reg_addr_t A_POL    = 8'h3C;

    // True when byte address a falls in the word at offset off.
    function automatic logic word_hit(input reg_addr_t a, input reg_addr_t off);
        return a[ADDR_W-1:2] == off[ADDR_W-1:2];
    endfunction

endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent (no bus coherency across bits).
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
// Module: software-visible configuration storage and output data, including
// the write-one set/clear path and the acknowledge pulse. Assumes a one-cycle
// write strobe; addresses not decoded here are ignored on write.
module gpio_regfile #(
    parameter int NPINS = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  gpio_irq_pkg::reg_addr_t       addr,
    input  logic [NPINS-1:0]              wdata,
    output logic [NPINS-1:0]              dout_q,
    output logic [NPINS-1:0]              dir_q,
    output logic [NPINS-1:0]              pen_q,
    output logic [NPINS-1:0]              ptyp_q,
    output logic [NPINS-1:0]              ien_q,
    output logic [NPINS-1:0]              mask_q,
    output logic [NPINS-1:0]              sense_q,
    output logic [NPINS-1:0]              both_q,
    output logic [NPINS-1:0]              pol_q,
    output logic [NPINS-1:0]              ack_bits
);
    import gpio_irq_pkg::*;

    // Output data: direct write, or bitwise set / clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                            dout_q <= '0;
        else if (wr_en && word_hit(addr, A_DOUT)) dout_q <= wdata;
        else if (wr_en && word_hit(addr, A_SET))  dout_q <= dout_q | wdata;
        else if (wr_en && word_hit(addr, A_CLR))  dout_q <= dout_q & ~wdata;
    end

    // Plain read/write configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            pen_q   <= '0;
            ptyp_q  <= '0;
            ien_q   <= '0;
            mask_q  <= '0;
            sense_q <= '0;
            both_q  <= '0;
            pol_q   <= '0;
        end else if (wr_en) begin
            if (word_hit(addr, A_DIR))   dir_q   <= wdata;
            if (word_hit(addr, A_PEN))   pen_q   <= wdata;
            if (word_hit(addr, A_PTYP))  ptyp_q  <= wdata;
            if (word_hit(addr, A_IEN))   ien_q   <= wdata;
            if (word_hit(addr, A_MASK))  mask_q  <= wdata;
            if (word_hit(addr, A_SENSE)) sense_q <= wdata;
            if (word_hit(addr, A_BOTH))  both_q  <= wdata;
            if (word_hit(addr, A_POL))   pol_q   <= wdata;
        end
    end

    // Acknowledge pulse: one cycle of write data when the ack word is hit.
    always_comb begin
        ack_bits = (wr_en && word_hit(addr, A_ACK)) ? wdata : '0;
    end

    // R3: bits written to the set word are 1 afterwards.
    p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && word_hit(addr, A_SET)) |-> ((dout_q & $past(wdata)) == $past(wdata)));

    // R3: bits written to the clear word are 0 afterwards.
    p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && word_hit(addr, A_CLR)) |-> ((dout_q & $past(wdata)) == '0));

    // R2: direction holds when no write occurred.
    p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(dir_q));
endmodule

// File: rtl/gpio_irq_detect.sv
// Module: per-pin interrupt detector. Edge events latch until acknowledged;
// level status follows the active condition. Assumes sync_in is already
// synchronised to clk.
module gpio_irq_detect #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] sync_in,
    input  logic [NPINS-1:0] ien,
    input  logic [NPINS-1:0] sense_lvl,
    input  logic [NPINS-1:0] both,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] ack,
    output logic [NPINS-1:0] raw_st
);
    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] raw_q;
    logic [NPINS-1:0] raw_d;

    // Keep last cycle's synchronised input for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in;
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic rise, fall, evt;
        // Next status for this pin from its trigger configuration.
        always_comb begin
            rise = sync_in[g] & ~prev_q[g];
            fall = ~sync_in[g] & prev_q[g];
            evt  = both[g] ? (rise | fall) : (pol[g] ? fall : rise);
            if (sense_lvl[g]) raw_d[g] = ien[g] & (sync_in[g] ^ pol[g]);
            else              raw_d[g] = ien[g] & ((raw_q[g] & ~ack[g]) | evt);
        end
    end

    // Register the status vector.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_d;
    end

    assign raw_st = raw_q;

    // R10: a pin disabled last cycle shows no status.
    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q & ~$past(ien)) == '0);

    // R6: a newly set edge-mode bit needs a change on the synchronised input.
    p_edge_needs_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q & ~$past(raw_q) & ~$past(sense_lvl) & ~$past(sync_in ^ prev_q)) == '0);

    // R8: an inactive level pin shows no status.
    p_level_inactive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sense_lvl) & ~$past(sync_in ^ pol) & raw_q) == '0);
endmodule

// File: rtl/gpio_irq_ctrl.sv
// Module: top of the GPIO controller. Ties the register file, the input
// synchroniser and the interrupt detector together and provides read-back.
// Assumes the bus samples bus_rdata combinationally from bus_addr.
module gpio_irq_ctrl #(
    parameter int NPINS = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               bus_wr,
    input  logic [gpio_irq_pkg::ADDR_W-1:0]    bus_addr,
    input  logic [NPINS-1:0]                   bus_wdata,
    output logic [NPINS-1:0]                   bus_rdata,
    input  logic [NPINS-1:0]                   pin_in,
    output logic [NPINS-1:0]                   pin_out,
    output logic [NPINS-1:0]                   pin_oe,
    output logic                               irq_out
);
    import gpio_irq_pkg::*;

    localparam int SYNC_STAGES = 2;

    logic [NPINS-1:0] dout_q, dir_q, pen_q, ptyp_q, ien_q, mask_q;
    logic [NPINS-1:0] sense_q, both_q, pol_q, ack_bits;
    logic [NPINS-1:0] pin_sync, raw_st, masked_st;

    gpio_regfile #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .dout_q(dout_q), .dir_q(dir_q), .pen_q(pen_q), .ptyp_q(ptyp_q),
        .ien_q(ien_q), .mask_q(mask_q), .sense_q(sense_q), .both_q(both_q),
        .pol_q(pol_q), .ack_bits(ack_bits)
    );

    gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    gpio_irq_detect #(.NPINS(NPINS)) u_det (
        .clk(clk), .rst_n(rst_n), .sync_in(pin_sync), .ien(ien_q),
        .sense_lvl(sense_q), .both(both_q), .pol(pol_q), .ack(ack_bits),
        .raw_st(raw_st)
    );

    // Masked status and combined interrupt.
    always_comb begin
        masked_st = raw_st & ~mask_q;
        irq_out   = |masked_st;
    end

    assign pin_out = dout_q;
    assign pin_oe  = dir_q;

    // Read-back multiplexer; write-only and unmapped words read 0.
    always_comb begin
        bus_rdata = '0;
        if      (word_hit(bus_addr, A_DOUT))  bus_rdata = dout_q;
        else if (word_hit(bus_addr, A_DIN))   bus_rdata = pin_sync;
        else if (word_hit(bus_addr, A_DIR))   bus_rdata = dir_q;
        else if (word_hit(bus_addr, A_PEN))   bus_rdata = pen_q;
        else if (word_hit(bus_addr, A_PTYP))  bus_rdata = ptyp_q;
        else if (word_hit(bus_addr, A_IEN))   bus_rdata = ien_q;
        else if (word_hit(bus_addr, A_RAW))   bus_rdata = raw_st;
        else if (word_hit(bus_addr, A_MSTAT)) bus_rdata = masked_st;
        else if (word_hit(bus_addr, A_MASK))  bus_rdata = mask_q;
        else if (word_hit(bus_addr, A_SENSE)) bus_rdata = sense_q;
        else if (word_hit(bus_addr, A_BOTH))  bus_rdata = both_q;
        else if (word_hit(bus_addr, A_POL))   bus_rdata = pol_q;
    end

    // R11: all pins masked means no interrupt.
    p_mask_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !irq_out);

    // R11: the interrupt needs some raw status behind it.
    p_irq_has_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (raw_st != '0));
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
// Bench: behavioural reference model with a pin-history queue, compared
// against every DUT output at each falling clock edge.
module gpio_irq_ctrl_tb;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out, pin_oe;
    logic          irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    gpio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // Reference model state
    logic [N-1:0] m_out, m_dir, m_pen, m_ptyp, m_ien, m_mask, m_sense, m_both, m_pol, m_raw;
    logic [N-1:0] hist [$];

    task automatic model_reset();
        m_out = '0; m_dir = '0; m_pen = '0; m_ptyp = '0; m_ien = '0;
        m_mask = '0; m_sense = '0; m_both = '0; m_pol = '0; m_raw = '0;
        hist.delete();
        for (int k = 0; k < 3; k++) hist.push_back('0);
    endtask

    initial model_reset();

    // Model update on each rising edge from the inputs held since the last drive.
    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            logic [N-1:0] cur, old, ack, nr;
            logic [5:0] w;
            cur = hist[1];
            old = hist[2];
            w = bus_addr[7:2];
            ack = (bus_wr && w == 6'h0C) ? bus_wdata : '0;
            for (int i = 0; i < N; i++) begin
                bit r, f, e;
                r = cur[i] && !old[i];
                f = !cur[i] && old[i];
                e = m_both[i] ? (r || f) : (m_pol[i] ? f : r);
                if (!m_ien[i])        nr[i] = 1'b0;
                else if (m_sense[i])  nr[i] = cur[i] ^ m_pol[i];
                else                  nr[i] = (m_raw[i] && !ack[i]) || e;
            end
            m_raw = nr;
            if (bus_wr) begin
                case (w)
                    6'h00: m_out   = bus_wdata;
                    6'h02: m_dir   = bus_wdata;
                    6'h04: m_out   = m_out | bus_wdata;
                    6'h05: m_out   = m_out & ~bus_wdata;
                    6'h06: m_pen   = bus_wdata;
                    6'h07: m_ptyp  = bus_wdata;
                    6'h08: m_ien   = bus_wdata;
                    6'h0B: m_mask  = bus_wdata;
                    6'h0D: m_sense = bus_wdata;
                    6'h0E: m_both  = bus_wdata;
                    6'h0F: m_pol   = bus_wdata;
                    default: ;
                endcase
            end
            hist.push_front(pin_in);
            void'(hist.pop_back());
        end
    end

    function automatic logic [N-1:0] exp_read(input logic [7:0] a);
        case (a[7:2])
            6'h00: return m_out;
            6'h01: return hist[1];
            6'h02: return m_dir;
            6'h06: return m_pen;
            6'h07: return m_ptyp;
            6'h08: return m_ien;
            6'h09: return m_raw;
            6'h0A: return m_raw & ~m_mask;
            6'h0B: return m_mask;
            6'h0D: return m_sense;
            6'h0E: return m_both;
            6'h0F: return m_pol;
            default: return '0;
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] a);
        case (a[7:2])
            6'h00, 6'h02: return "R2";
            6'h01:        return "R4";
            6'h04, 6'h05: return "R3";
            6'h06, 6'h07: return "R5";
            6'h08:        return "R10";
            6'h09:        return "R6";
            6'h0A, 6'h0B: return "R11";
            6'h0C:        return "R9";
            6'h0D:        return "R8";
            6'h0E:        return "R7";
            6'h0F:        return "R6";
            default:      return "R12";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2", "pin_out", pin_out, m_out);
            check("R2", "pin_oe", pin_oe, m_dir);
            check("R11", "irq_out", {{(N-1){1'b0}}, irq_out}, {{(N-1){1'b0}}, |(m_raw & ~m_mask)});
            check(req_of(bus_addr), $sformatf("read %h", bus_addr), bus_rdata, exp_read(bus_addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
        @(posedge clk); #2;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(posedge clk); #2;
        bus_addr = a;
    endtask

    task automatic pins(input logic [N-1:0] v, input int hold);
        @(posedge clk); #2;
        pin_in = v;
        for (int k = 0; k < hold; k++) @(posedge clk);
    endtask

    task automatic scan_all();
        for (int a = 0; a < 64; a += 4) rd(a[7:0]);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #8;
        // R1: reset state at the ports
        check("R1", "pin_out reset", pin_out, '0);
        check("R1", "pin_oe reset", pin_oe, '0);
        check("R1", "irq reset", {{(N-1){1'b0}}, irq_out}, '0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        scan_all();                                  // R1, R12: all reads zero

        // R2, R3: data, direction, set and clear
        wr(8'h00, 32'hA5A5_5A5A);
        wr(8'h08, 32'hFFFF_0000);
        wr(8'h10, 32'h0000_000F);                    // R3 set
        wr(8'h14, 32'hA000_0000);                    // R3 clear
        wr(8'h10, 32'h0);                            // R3 zero bits: no change
        rd(8'h00); rd(8'h10); rd(8'h14);
        // R5: pull storage
        wr(8'h18, 32'h1234_5678);
        wr(8'h1C, 32'h8765_4321);
        rd(8'h18); rd(8'h1C);
        // R12: read-only writes ignored, unmapped reads zero
        wr(8'h04, 32'hFFFF_FFFF); wr(8'h24, 32'hFFFF_FFFF); wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h0C); rd(8'h40); rd(8'hFC); rd(8'h27);
        // R4: input sampling latency
        rd(8'h04);
        pins(32'hDEAD_BEEF, 1); pins(32'h0F0F_0F0F, 3);

        // R6/R7/R8 config: pin0 rise, pin1 fall, pin2 both, pin3 level-high, pin4 level-low
        pins(32'h0, 3);
        wr(8'h34, 32'h0000_0018);
        wr(8'h3C, 32'h0000_0012);
        wr(8'h38, 32'h0000_0004);
        wr(8'h20, 32'hFFFF_FFFF);                    // R10 enable
        rd(8'h24);
        pins(32'h0000_001F, 4);                      // R6 rise, R7 both, R8 levels
        pins(32'h0000_0000, 4);                      // R6 fall
        rd(8'h28);
        wr(8'h30, 32'hFFFF_FFFF);                    // R9 clear all
        rd(8'h24);
        pins(32'h0000_0008, 3);                      // R8 level stays through ack
        wr(8'h30, 32'h0000_0008);
        rd(8'h24);
        // R9: edge in same cycle as ack wins
        @(posedge clk); #2; pin_in = 32'h0000_0009;
        @(posedge clk); @(posedge clk); #2;
        bus_wr = 1'b1; bus_addr = 8'h30; bus_wdata = 32'h0000_0001;
        @(posedge clk); #2; bus_wr = 1'b0; bus_addr = 8'h24;
        repeat (2) @(posedge clk);
        // R11: mask
        wr(8'h2C, 32'hFFFF_FFFF); rd(8'h28);
        wr(8'h2C, 32'h0000_0001); rd(8'h28);
        // R10: disable clears status, re-enable forgets
        wr(8'h20, 32'h0); rd(8'h24);
        pins(32'h0000_0000, 3);
        wr(8'h20, 32'hFFFF_FFFF); rd(8'h24);

        // Mixed random traffic across all registers and modes (R2..R12)
        for (int it = 0; it < 3000; it++) begin
            int c;
            c = $urandom_range(0, 9);
            if (c < 4) begin
                pins($urandom(), 0);
            end else if (c < 7) begin
                logic [7:0] a;
                a = 8'($urandom_range(0, 15) * 4);
                wr(a, $urandom());
            end else begin
                rd(8'($urandom_range(0, 17) * 4));
            end
        end
        scan_all();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule